// File: doc/BRIEF.md
# OLED Controller Command and Pixel Stream Decoder

This block sits behind a two-wire bus target that has already assembled incoming bytes. It takes them one at a time through a valid strobe, and it also receives a pulse when the bus transfer stops. A leading control byte chooses between a command and a pixel-data transfer. Commands update the display state registers: column pointer, page pointer, and four display flags (horizontal mirror, force-all-lit, inverse video, panel enable). Pixel bytes go out on a write port into a framebuffer of 132 columns by 8 pages of bytes.

A command that carries an argument byte puts the decoder into a discard state. The argument must still be sent under its own command control byte, and it is dropped. Unrecognised bytes give a one-cycle error pulse. Every output is registered, and a byte is reflected at the ports one clock edge after the cycle in which it was presented.

Top module: `oled_stream_decoder`

## Requirements
- R1: In idle, byte 0x80 enters command mode and byte 0x40 enters data mode. Any other byte pulses `err_o` for one cycle and the block stays idle (`cmd_mode_o`=`data_mode_o`=0).
- R2: In data mode, a byte with column c < 132 writes `fb_wdata`=byte to `fb_addr`=c+page*132 with a one-cycle `fb_we`, and the column becomes c+1. When c >= 132 there is no write and the column does not change.
- R3: Data mode stays on across any number of bytes until `in_stop`. A byte presented in the same cycle as `in_stop` is still processed, and the block is idle afterwards.
- R4: Exactly one byte is taken in command mode, and then the block returns to idle.
- R5: Commands 0x00–0x0F replace column bits [3:0] with the command's low nibble. Commands 0x10–0x20 replace column bits [7:4] with the command's low nibble.
- R6: Commands 0xB0–0xBF load the page with command bits [2:0].
- R7: 0xA0/0xA1 clear/set mirror, 0xA4/0xA5 clear/set all-lit, 0xA6/0xA7 clear/set inverse, and 0xAE/0xAF clear/set panel enable.
- R8: 0x81, 0xA8, 0xAD, 0xD3, 0xD5, 0xD8, 0xD9, 0xDA and 0xDB arm a discard state. The next byte taken in command mode has no effect and raises no error, and it clears the discard state. Control bytes in idle do not consume it.
- R9: 0xE3, 0x40–0x7F and 0xC0–0xC8 change nothing and raise no error. Every other unlisted command pulses `err_o` for one cycle and changes no column, page or flag.
- R10: Any framebuffer write sets `redraw_o`, which then stays set until reset.
- R11: Synchronous reset clears column, page, flags, redraw, error, write strobe and the discard state, and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received byte is present |
| in_byte | input | 8 | Received byte |
| in_stop | input | 1 | Bus stop condition pulse |
| fb_we | output | 1 | Framebuffer write strobe |
| fb_addr | output | 11 | Framebuffer byte address |
| fb_wdata | output | 8 | Framebuffer write data |
| col_o | output | 8 | Column pointer |
| page_o | output | 3 | Page pointer |
| cmd_mode_o | output | 1 | Command mode active |
| data_mode_o | output | 1 | Data mode active |
| mirror_o | output | 1 | Horizontal mirror flag |
| all_on_o | output | 1 | Force-all-lit flag |
| inverse_o | output | 1 | Inverse video flag |
| disp_en_o | output | 1 | Panel enable flag |
| redraw_o | output | 1 | Framebuffer changed since reset |
| err_o | output | 1 | One-cycle error pulse |

## Verification
Every effect of a byte is due exactly one rising edge after the cycle in which `in_valid` is high. This covers the mode change, the column and page update, the flag change, the write strobe with its address and data, the redraw set and the error pulse. The bench drives inputs on the falling edge. Its behavioural model advances on the same rising edge as the design, and all ports are compared at the next falling edge, so the single-cycle `fb_we` and `err_o` pulses are caught in their only valid cycle. Directed checks after each byte sample at that same falling edge.

// File: rtl/oled_dec_pkg.sv
package oled_dec_pkg;
  localparam int COL_W  = 8;
  localparam int NIB_W  = 4;
  localparam int NFLAGS = 4;
  localparam int FLAG_W = $clog2(NFLAGS);

  localparam logic [7:0] CTRL_TO_CMD  = 8'h80;
  localparam logic [7:0] CTRL_TO_DATA = 8'h40;

  localparam int FLAG_MIRROR = 0;
  localparam int FLAG_ALLON  = 1;
  localparam int FLAG_INV    = 2;
  localparam int FLAG_EN     = 3;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_CMD  = 2'd1,
    MODE_DATA = 2'd2
  } mode_e;

  typedef struct packed {
    logic              col_lo;
    logic              col_hi;
    logic              page;
    logic              flag;
    logic [FLAG_W-1:0] flag_idx;
    logic              skip;
    logic              bad;
  } cmd_dec_t;
endpackage

// File: rtl/oled_cmd_decode.sv
module oled_cmd_decode
  import oled_dec_pkg::*;
(
  input  logic [7:0] code,
  output cmd_dec_t   dec
);
  always_comb begin
    dec = '0;
    if (code <= 8'h0F) begin
      dec.col_lo = 1'b1;
    end else if (code <= 8'h20) begin
      dec.col_hi = 1'b1;
    end else if (code inside {[8'h40:8'h7F]}) begin
      dec = '0;
    end else if (code inside {[8'hB0:8'hBF]}) begin
      dec.page = 1'b1;
    end else if (code inside {[8'hC0:8'hC8]}) begin
      dec = '0;
    end else begin
      case (code)
        8'hA0, 8'hA1: begin dec.flag = 1'b1; dec.flag_idx = FLAG_W'(FLAG_MIRROR); end
        8'hA4, 8'hA5: begin dec.flag = 1'b1; dec.flag_idx = FLAG_W'(FLAG_ALLON);  end
        8'hA6, 8'hA7: begin dec.flag = 1'b1; dec.flag_idx = FLAG_W'(FLAG_INV);    end
        8'hAE, 8'hAF: begin dec.flag = 1'b1; dec.flag_idx = FLAG_W'(FLAG_EN);     end
        8'h81, 8'hA8, 8'hAD, 8'hD3, 8'hD5,
        8'hD8, 8'hD9, 8'hDA, 8'hDB:  dec.skip = 1'b1;
        8'hE3:                       dec.bad  = 1'b0;
        default:                     dec.bad  = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/oled_flag_bank.sv
module oled_flag_bank #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic             val,
  output logic [N-1:0]     flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic r;
    always_ff @(posedge clk) begin
      if (rst)                            r <= 1'b0;
      else if (we && idx == IDX_W'(i))    r <= val;
    end
    assign flags[i] = r;
  end
endmodule

// File: rtl/oled_addr_unit.sv
module oled_addr_unit
  import oled_dec_pkg::*;
#(
  parameter int COLS  = 132,
  parameter int PAGES = 8,
  localparam int ADDR_W = $clog2(COLS * PAGES),
  localparam int PAGE_W = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_en,
  input  logic [7:0]        wdata,
  input  logic              col_lo_we,
  input  logic              col_hi_we,
  input  logic [NIB_W-1:0]  nib,
  input  logic              page_we,
  input  logic [PAGE_W-1:0] page_val,
  output logic              wr_go,
  output logic [COL_W-1:0]  col,
  output logic [PAGE_W-1:0] page,
  output logic              fb_we,
  output logic [ADDR_W-1:0] fb_addr,
  output logic [7:0]        fb_wdata
);
  localparam logic [COL_W-1:0] COL_LIM = COL_W'(COLS);

  logic [ADDR_W-1:0] lin_addr;

  assign wr_go    = data_en && (col < COL_LIM);
  assign lin_addr = ADDR_W'(col) + ADDR_W'(page) * ADDR_W'(COLS);

  always_ff @(posedge clk) begin
    if (rst) begin
      col      <= '0;
      page     <= '0;
      fb_we    <= 1'b0;
      fb_addr  <= '0;
      fb_wdata <= '0;
    end else begin
      fb_we <= 1'b0;
      if (wr_go) begin
        fb_we    <= 1'b1;
        fb_addr  <= lin_addr;
        fb_wdata <= wdata;
        col      <= col + 1'b1;
      end
      if (col_lo_we) col <= {col[COL_W-1:NIB_W], nib};
      if (col_hi_we) col <= {nib, col[NIB_W-1:0]};
      if (page_we)   page <= page_val;
    end
  end
endmodule

// File: rtl/oled_stream_decoder.sv
module oled_stream_decoder
  import oled_dec_pkg::*;
#(
  parameter int COLS  = 132,
  parameter int PAGES = 8,
  localparam int ADDR_W = $clog2(COLS * PAGES),
  localparam int PAGE_W = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              in_stop,
  output logic              fb_we,
  output logic [ADDR_W-1:0] fb_addr,
  output logic [7:0]        fb_wdata,
  output logic [COL_W-1:0]  col_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              cmd_mode_o,
  output logic              data_mode_o,
  output logic              mirror_o,
  output logic              all_on_o,
  output logic              inverse_o,
  output logic              disp_en_o,
  output logic              redraw_o,
  output logic              err_o
);
  mode_e       mode_q;
  logic        skip_q;
  logic        redraw_q;
  logic        err_q;
  cmd_dec_t    dec;
  logic        cmd_take;
  logic        cmd_live;
  logic        data_en;
  logic        wr_go;
  logic [NFLAGS-1:0] flags;

  assign cmd_take = in_valid && (mode_q == MODE_CMD);
  assign cmd_live = cmd_take && !skip_q;
  assign data_en  = in_valid && (mode_q == MODE_DATA);

  oled_cmd_decode u_dec (
    .code (in_byte),
    .dec  (dec)
  );

  oled_addr_unit #(.COLS(COLS), .PAGES(PAGES)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .data_en   (data_en),
    .wdata     (in_byte),
    .col_lo_we (cmd_live && dec.col_lo),
    .col_hi_we (cmd_live && dec.col_hi),
    .nib       (in_byte[NIB_W-1:0]),
    .page_we   (cmd_live && dec.page),
    .page_val  (in_byte[PAGE_W-1:0]),
    .wr_go     (wr_go),
    .col       (col_o),
    .page      (page_o),
    .fb_we     (fb_we),
    .fb_addr   (fb_addr),
    .fb_wdata  (fb_wdata)
  );

  oled_flag_bank #(.N(NFLAGS)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .we    (cmd_live && dec.flag),
    .idx   (dec.flag_idx),
    .val   (in_byte[0]),
    .flags (flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_IDLE;
      skip_q   <= 1'b0;
      redraw_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (wr_go) redraw_q <= 1'b1;
      if (in_valid) begin
        case (mode_q)
          MODE_IDLE: begin
            if (in_byte == CTRL_TO_CMD)       mode_q <= MODE_CMD;
            else if (in_byte == CTRL_TO_DATA) mode_q <= MODE_DATA;
            else                              err_q  <= 1'b1;
          end
          MODE_CMD: begin
            mode_q <= MODE_IDLE;
            if (skip_q) begin
              skip_q <= 1'b0;
            end else begin
              if (dec.skip) skip_q <= 1'b1;
              if (dec.bad)  err_q  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (in_stop) mode_q <= MODE_IDLE;
    end
  end

  assign cmd_mode_o  = (mode_q == MODE_CMD);
  assign data_mode_o = (mode_q == MODE_DATA);
  assign mirror_o    = flags[FLAG_MIRROR];
  assign all_on_o    = flags[FLAG_ALLON];
  assign inverse_o   = flags[FLAG_INV];
  assign disp_en_o   = flags[FLAG_EN];
  assign redraw_o    = redraw_q;
  assign err_o       = err_q;
endmodule

// File: rtl/oled_decoder_chk.sv
module oled_decoder_chk #(
  parameter int COLS  = 132,
  parameter int PAGES = 8,
  localparam int ADDR_W = $clog2(COLS * PAGES),
  localparam int PAGE_W = $clog2(PAGES)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_stop,
  input logic              fb_we,
  input logic [ADDR_W-1:0] fb_addr,
  input logic [7:0]        col_o,
  input logic [PAGE_W-1:0] page_o,
  input logic              cmd_mode_o,
  input logic              data_mode_o,
  input logic              mirror_o,
  input logic              all_on_o,
  input logic              inverse_o,
  input logic              disp_en_o,
  input logic              redraw_o,
  input logic              err_o
);
  a_r1_one_mode: assert property (@(posedge clk) disable iff (rst)
    !(cmd_mode_o && data_mode_o));

  a_r2_write_from_data: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> ($past(in_valid) && $past(data_mode_o)));

  a_r2_col_advances: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> (col_o == 8'($past(col_o) + 8'd1)));

  a_r2_addr_in_range: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> (fb_addr < ADDR_W'(COLS * PAGES)));

  a_r3_stop_idles: assert property (@(posedge clk) disable iff (rst)
    in_stop |=> (!cmd_mode_o && !data_mode_o));

  a_r9_err_quiet: assert property (@(posedge clk) disable iff (rst)
    err_o |-> ($stable(col_o) && $stable(page_o) &&
               $stable({mirror_o, all_on_o, inverse_o, disp_en_o})));

  a_r10_redraw_sticky: assert property (@(posedge clk) disable iff (rst)
    redraw_o |=> redraw_o);

  a_r10_redraw_on_write: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> redraw_o);
endmodule

bind oled_stream_decoder oled_decoder_chk #(.COLS(COLS), .PAGES(PAGES)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_stop(in_stop),
  .fb_we(fb_we), .fb_addr(fb_addr), .col_o(col_o), .page_o(page_o),
  .cmd_mode_o(cmd_mode_o), .data_mode_o(data_mode_o), .mirror_o(mirror_o),
  .all_on_o(all_on_o), .inverse_o(inverse_o), .disp_en_o(disp_en_o),
  .redraw_o(redraw_o), .err_o(err_o)
);

// File: tb/sim_oled_stream_decoder.sv
`timescale 1ns/1ps
module sim_oled_stream_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_stop = 1'b0;
  logic fb_we;
  logic [10:0] fb_addr;
  logic [7:0] fb_wdata;
  logic [7:0] col_o;
  logic [2:0] page_o;
  logic cmd_mode_o, data_mode_o, mirror_o, all_on_o, inverse_o, disp_en_o;
  logic redraw_o, err_o;

  always #2 clk = ~clk;

  oled_stream_decoder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_stop(in_stop),
    .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata), .col_o(col_o),
    .page_o(page_o), .cmd_mode_o(cmd_mode_o), .data_mode_o(data_mode_o),
    .mirror_o(mirror_o), .all_on_o(all_on_o), .inverse_o(inverse_o),
    .disp_en_o(disp_en_o), .redraw_o(redraw_o), .err_o(err_o)
  );

  int compared = 0;
  int mismatched = 0;
  string phase = "R11 reset";
  bit started = 0;
  bit done = 0;

  // behavioural reference model: mode 0 idle, 1 command, 2 data
  int m_mode, m_skip, m_col, m_page, m_mir, m_on, m_inv, m_en;
  int m_redraw, m_err, m_we, m_addr, m_wd;

  task automatic model_cmd(input int b);
    if (b < 16)                      m_col = (m_col & 240) | (b & 15);
    else if (b <= 32)                m_col = (m_col & 15) | ((b & 15) << 4);
    else if (b >= 64 && b <= 127)    m_col = m_col;
    else if (b >= 176 && b <= 191)   m_page = b & 7;
    else if (b >= 192 && b <= 200)   m_col = m_col;
    else case (b)
      'hA0: m_mir = 0;  'hA1: m_mir = 1;
      'hA4: m_on  = 0;  'hA5: m_on  = 1;
      'hA6: m_inv = 0;  'hA7: m_inv = 1;
      'hAE: m_en  = 0;  'hAF: m_en  = 1;
      'h81, 'hA8, 'hAD, 'hD3, 'hD5, 'hD8, 'hD9, 'hDA, 'hDB: m_skip = 1;
      'hE3: m_col = m_col;
      default: m_err = 1;
    endcase
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_skip = 0; m_col = 0; m_page = 0;
      m_mir = 0; m_on = 0; m_inv = 0; m_en = 0;
      m_redraw = 0; m_err = 0; m_we = 0; m_addr = 0; m_wd = 0;
      started = 1;
    end else begin
      m_we = 0; m_err = 0;
      if (in_valid) begin
        if (m_mode == 0) begin
          if (in_byte == 8'h80)      m_mode = 1;
          else if (in_byte == 8'h40) m_mode = 2;
          else                       m_err = 1;
        end else if (m_mode == 1) begin
          m_mode = 0;
          if (m_skip != 0) m_skip = 0;
          else model_cmd(int'(in_byte));
        end else if (m_col < 132) begin
          m_we = 1; m_addr = m_col + m_page * 132; m_wd = int'(in_byte);
          m_col = m_col + 1; m_redraw = 1;
        end
      end
      if (in_stop) m_mode = 0;
    end
  end

  task automatic field(input string name, input int act, input int exp);
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: %s actual=%0d expected=%0d @%0t", phase, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      compared++;
      field("cmd_mode", int'(cmd_mode_o), int'(m_mode == 1));
      field("data_mode", int'(data_mode_o), int'(m_mode == 2));
      field("col", int'(col_o), m_col);
      field("page", int'(page_o), m_page);
      field("mirror", int'(mirror_o), m_mir);
      field("all_on", int'(all_on_o), m_on);
      field("inverse", int'(inverse_o), m_inv);
      field("disp_en", int'(disp_en_o), m_en);
      field("redraw", int'(redraw_o), m_redraw);
      field("err", int'(err_o), m_err);
      field("fb_we", int'(fb_we), m_we);
      if (m_we != 0) begin
        field("fb_addr", int'(fb_addr), m_addr);
        field("fb_wdata", int'(fb_wdata), m_wd);
      end
    end
  end

  task automatic expect_eq(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic put(input logic [7:0] b, input bit s);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_stop = s;
    @(negedge clk);
    in_valid = 1'b0; in_stop = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);
    put(8'h80, 1'b0);
    put(b, 1'b0);
  endtask

  task automatic stop_only();
    @(negedge clk); in_stop = 1'b1;
    @(negedge clk); in_stop = 1'b0;
  endtask

  task automatic report();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual=expired expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_eq("R11 reset col", int'(col_o), 0);
    expect_eq("R11 reset modes", int'({cmd_mode_o, data_mode_o}), 0);
    rst = 1'b0;

    phase = "R1 control";
    put(8'h55, 1'b0);
    expect_eq("R1 bad idle byte err", int'(err_o), 1);
    expect_eq("R1 stays idle", int'({cmd_mode_o, data_mode_o}), 0);
    put(8'h80, 1'b0);
    expect_eq("R1 enter command", int'(cmd_mode_o), 1);
    put(8'hA7, 1'b0);
    expect_eq("R7 inverse set", int'(inverse_o), 1);
    expect_eq("R4 back to idle", int'(cmd_mode_o), 0);

    phase = "R5 R6 addressing";
    cmd(8'h03); cmd(8'h18);
    expect_eq("R5 col nibbles", int'(col_o), 131);
    cmd(8'hB5);
    expect_eq("R6 page", int'(page_o), 5);

    phase = "R2 R3 data";
    put(8'h40, 1'b0);
    expect_eq("R1 enter data", int'(data_mode_o), 1);
    put(8'hAA, 1'b0);
    expect_eq("R2 write strobe", int'(fb_we), 1);
    expect_eq("R2 write addr", int'(fb_addr), 791);
    expect_eq("R2 write data", int'(fb_wdata), 8'hAA);
    expect_eq("R10 redraw set", int'(redraw_o), 1);
    put(8'hBB, 1'b0);
    expect_eq("R2 suppressed", int'(fb_we), 0);
    expect_eq("R2 col held", int'(col_o), 132);
    expect_eq("R3 data persists", int'(data_mode_o), 1);
    stop_only();
    expect_eq("R3 stop idles", int'(data_mode_o), 0);

    phase = "R5 R6 high nibble";
    cmd(8'h20);
    expect_eq("R5 0x20 clears high", int'(col_o), 4);
    cmd(8'hBF);
    expect_eq("R6 page low bits", int'(page_o), 7);

    phase = "R8 skip";
    cmd(8'h81);
    cmd(8'hAF);
    expect_eq("R8 argument dropped", int'(disp_en_o), 0);
    cmd(8'hAF);
    expect_eq("R8 skip cleared", int'(disp_en_o), 1);
    cmd(8'hD8);
    put(8'h80, 1'b0);
    expect_eq("R8 control not consumed", int'(cmd_mode_o), 1);
    put(8'hA1, 1'b0);
    expect_eq("R8 second drop", int'(mirror_o), 0);

    phase = "R9 no-ops and errors";
    cmd(8'hE3); cmd(8'h55); cmd(8'hC4);
    expect_eq("R9 no-op err", int'(err_o), 0);
    expect_eq("R9 no-op col", int'(col_o), 4);
    cmd(8'hC9);
    expect_eq("R9 unknown err", int'(err_o), 1);
    cmd(8'h21);
    expect_eq("R9 unknown err2", int'(err_o), 1);
    expect_eq("R9 col unchanged", int'(col_o), 4);

    phase = "R7 flags";
    cmd(8'hA1); cmd(8'hA5); cmd(8'hA6); cmd(8'hAE);
    expect_eq("R7 mirror", int'(mirror_o), 1);
    expect_eq("R7 all_on", int'(all_on_o), 1);
    expect_eq("R7 inverse clr", int'(inverse_o), 0);
    expect_eq("R7 enable clr", int'(disp_en_o), 0);

    phase = "R3 stop with byte";
    put(8'h40, 1'b0);
    put(8'h11, 1'b1);
    expect_eq("R3 last byte written", int'(fb_addr), 928);
    expect_eq("R3 idle after", int'(data_mode_o), 0);
    expect_eq("R3 col advanced", int'(col_o), 5);
    put(8'h12, 1'b0);
    expect_eq("R1 idle error after stop", int'(err_o), 1);

    phase = "R11 mid reset";
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    expect_eq("R11 redraw cleared", int'(redraw_o), 0);
    expect_eq("R11 mirror cleared", int'(mirror_o), 0);

    phase = "R1-mixed random stream";
    for (int i = 0; i < 600; i++) begin
      int r;
      logic [7:0] b;
      r = int'($urandom_range(0, 99));
      if (r < 30)      b = 8'h80;
      else if (r < 45) b = 8'h40;
      else             b = 8'($urandom_range(0, 255));
      put(b, ($urandom_range(0, 19) == 0));
    end

    repeat (2) @(negedge clk);
    report();
  end
endmodule